// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register mailbox between a host bus and an embedded display controller. The host fills a 32-bit data word and a 32-bit command word (four byte lanes, written under per-lane byte enables), then rings a doorbell by setting the handshake bit in the control word. That same bit is the busy flag: while it reads 1 the mailbox holds a command the controller has not yet taken, and the host must wait for it to return to 0 before writing again.

The handshake bit drives the interrupt line to the controller. When the controller answers with a done pulse, the mailbox clears the bit on the next clock. In that same cycle it emits a one-cycle command-valid strobe carrying the decoded command: its kind, its operand byte, the data word and an immediate-disable flag. Command byte 0 is the opcode. 0x65 means set level, and its operand is command byte 2. 0x66 means select pipe, and its operand is command byte 1. A pipe index of 0xFF requests immediate disable. 0x67 means set backlight, and its operand is command byte 1, the controller index; the frame-ramp data word is forced to 0 when that index is 0.

The sequencer has two states. IDLE moves to BUSY on a doorbell write. BUSY moves back to IDLE on a done pulse, and that transition retires the command. No other transitions exist.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the handshake bit, the interrupt output, the data word, the command word, the overrun flag and the command-valid strobe are all 0.
- R2: A bus write to the control word (address 0) with bit 0 set, while the handshake bit is 0, sets the handshake bit (IDLE to BUSY). The interrupt output is 1 and control read bit 0 is 1 from the next cycle on.
- R3: While the handshake bit is 0, a write to the data word (address 1) or the command word (address 2) updates only the byte lanes whose byte enable is set. Address 3 reads 0.
- R4: A write to address 1 or 2 while the handshake bit is 1 leaves both words unchanged. It sets the overrun flag (control read bit 1), which stays set until reset.
- R5: A done pulse in BUSY clears the handshake bit on the next clock (BUSY to IDLE). In that same cycle the command-valid strobe is high for exactly one cycle.
- R6: A done pulse in IDLE produces no strobe and changes no state.
- R7: The decoded kind is encoded 1 for opcode 0x65, with the operand taken from byte 2. It is 2 for 0x66 and 3 for 0x67, each with the operand taken from byte 1. Any other opcode gives kind 0 with operand 0.
- R8: The immediate-disable output is 1 with the strobe only for opcode 0x66 with byte 1 equal to 0xFF.
- R9: The delivered data word equals the data register, except for opcode 0x67 with byte 1 equal to 0, where it is 0.
- R10: A control write while BUSY, with bit 0 either 0 or 1, neither clears the handshake bit nor sets the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 command |
| bus_be | input | 4 | Byte enables for data and command writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mcu_irq | output | 1 | Doorbell to the controller (handshake bit) |
| mcu_done | input | 1 | Controller has taken the command |
| cmd_valid | output | 1 | One-cycle retire strobe |
| cmd_kind | output | 2 | Decoded kind: 0 other, 1 level, 2 pipe, 3 backlight |
| cmd_operand | output | 8 | Operand byte chosen by the opcode |
| cmd_data | output | 32 | Data word delivered with the command |
| cmd_disable | output | 1 | Pipe command asks for immediate disable |

## Verification
Each opcode is sent with operand values that sit in the byte lane it does not use, so a wrong lane choice shows up as a wrong operand. Backlight commands are sent with controller index 0 and with a non-zero index, and pipe commands with index 0xFF and with an ordinary index; these pairs separate the forced-zero and disable cases from normal delivery. Partial byte-enable writes show whether lanes are isolated. Writes and done pulses arriving in the wrong state show whether the busy gating and the overrun flag work.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;

    typedef enum logic [1:0] {
        KIND_OTHER     = 2'd0,
        KIND_LEVEL     = 2'd1,
        KIND_PIPE      = 2'd2,
        KIND_BACKLIGHT = 2'd3
    } cmd_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mbx_state_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [7:0]         operand;
        logic [WORD_W-1:0]  data;
        logic               disable_now;
    } cmd_t;
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LANES-1:0]   be,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               busy,
    output logic [WORD_W-1:0]  data_q,
    output logic [WORD_W-1:0]  cmd_q,
    output logic               overrun_q,
    output logic               ring
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(2);

    logic wr_data, wr_cmd;
    assign wr_data = wr && !busy && (addr == A_DATA);
    assign wr_cmd  = wr && !busy && (addr == A_CMD);
    assign ring    = wr && !busy && (addr == A_CTRL) && wdata[0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[8*i +: 8] <= '0;
                cmd_q[8*i +: 8]  <= '0;
            end else begin
                if (wr_data && be[i]) data_q[8*i +: 8] <= wdata[8*i +: 8];
                if (wr_cmd && be[i])  cmd_q[8*i +: 8]  <= wdata[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun_q <= 1'b0;
        else if (wr && busy && (addr == A_DATA || addr == A_CMD))
            overrun_q <= 1'b1;
    end

    // R4
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_q) && $stable(data_q)));
    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |=> overrun_q);
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter logic [7:0] OPC_LEVEL     = 8'h65,
    parameter logic [7:0] OPC_PIPE      = 8'h66,
    parameter logic [7:0] OPC_BACKLIGHT = 8'h67,
    parameter logic [7:0] PIPE_KILL     = 8'hFF
) (
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WORD_W-1:0] data_word,
    output cmd_t              dec
);
    logic [7:0] opc, lane1, lane2;
    assign opc   = cmd_word[7:0];
    assign lane1 = cmd_word[15:8];
    assign lane2 = cmd_word[23:16];

    always_comb begin
        dec.kind        = KIND_OTHER;
        dec.operand     = 8'h00;
        dec.data        = data_word;
        dec.disable_now = 1'b0;
        if (opc == OPC_LEVEL) begin
            dec.kind    = KIND_LEVEL;
            dec.operand = lane2;
        end else if (opc == OPC_PIPE) begin
            dec.kind        = KIND_PIPE;
            dec.operand     = lane1;
            dec.disable_now = (lane1 == PIPE_KILL);
        end else if (opc == OPC_BACKLIGHT) begin
            dec.kind    = KIND_BACKLIGHT;
            dec.operand = lane1;
            if (lane1 == 8'h00) dec.data = '0;
        end
    end
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic done,
    input  cmd_t dec,
    output logic busy,
    output logic valid_q,
    output cmd_t out_q
);
    mbx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ring) state_d = ST_BUSY;
            ST_BUSY: if (done) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= (state_q == ST_BUSY) && done;
            if ((state_q == ST_BUSY) && done) out_q <= dec;
        end
    end

    assign busy = (state_q == ST_BUSY);

    // R2
    ring_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ring) |=> busy);
    // R5
    done_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (!busy && valid_q));
    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R6
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !valid_q);
    // R10
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mcu_irq,
    input  logic        mcu_done,
    output logic        cmd_valid,
    output logic [1:0]  cmd_kind,
    output logic [7:0]  cmd_operand,
    output logic [31:0] cmd_data,
    output logic        cmd_disable
);
    logic [WORD_W-1:0] data_q, cmd_q;
    logic              overrun_q, ring, busy;
    cmd_t              dec, out_q;

    mbx_regs #(.ADDR_W(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
        .wdata(bus_wdata), .busy(busy), .data_q(data_q), .cmd_q(cmd_q),
        .overrun_q(overrun_q), .ring(ring)
    );

    mbx_decode u_dec (.cmd_word(cmd_q), .data_word(data_q), .dec(dec));

    mbx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ring(ring), .done(mcu_done), .dec(dec),
        .busy(busy), .valid_q(cmd_valid), .out_q(out_q)
    );

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = {30'd0, overrun_q, busy};
            2'd1:    bus_rdata = data_q;
            2'd2:    bus_rdata = cmd_q;
            default: bus_rdata = '0;
        endcase
    end

    assign mcu_irq     = busy;
    assign cmd_kind    = out_q.kind;
    assign cmd_operand = out_q.operand;
    assign cmd_data    = out_q.data;
    assign cmd_disable = out_q.disable_now;

    // R8
    disable_only_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_disable) |-> (cmd_kind == 2'd2 && cmd_operand == 8'hFF));
endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  operand;
        logic [31:0] data;
        logic        dis;
    } exp_t;

    logic        clk = 0, rst_n = 0, bus_wr = 0, mcu_done = 0;
    logic [1:0]  bus_addr = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, cmd_data;
    logic        mcu_irq, cmd_valid, cmd_disable;
    logic [1:0]  cmd_kind;
    logic [7:0]  cmd_operand;

    int checks = 0, failures = 0;
    bit finished = 0;
    exp_t expq[$];

    cmd_mailbox uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mcu_irq(mcu_irq), .mcu_done(mcu_done), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_operand(cmd_operand), .cmd_data(cmd_data),
        .cmd_disable(cmd_disable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_be = 0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        mcu_done = 1;
        @(negedge clk);
        mcu_done = 0;
    endtask

    task automatic send(input logic [31:0] cmdw, input logic [31:0] dataw, input exp_t e);
        bus_write(2'd1, 4'hF, dataw);
        bus_write(2'd2, 4'hF, cmdw);
        bus_write(2'd0, 4'hF, 32'h1);
        check(mcu_irq == 1'b1, "R2", mcu_irq, 1);
        expq.push_back(e);
        pulse_done();
        check(mcu_irq == 1'b0, "R5", mcu_irq, 0);
        @(negedge clk);
        check(cmd_valid == 1'b0, "R5", cmd_valid, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (expq.size() == 0) begin
                check(0, "R6", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cmd_kind == e.kind, "R7", cmd_kind, e.kind);
                check(cmd_operand == e.operand, "R7", cmd_operand, e.operand);
                check(cmd_data == e.data, "R9", cmd_data, e.data);
                check(cmd_disable == e.dis, "R8", cmd_disable, e.dis);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(mcu_irq == 0, "R1", mcu_irq, 0);
        check(cmd_valid == 0, "R1", cmd_valid, 0);
        read_chk(2'd0, 32'h0, "R1");
        read_chk(2'd1, 32'h0, "R1");
        read_chk(2'd2, 32'h0, "R1");

        // R3 byte lanes
        bus_write(2'd1, 4'hF, 32'h11223344);
        bus_write(2'd1, 4'b0010, 32'hFFFFAAFF);
        read_chk(2'd1, 32'h1122AA44, "R3");
        bus_write(2'd2, 4'b0011, 32'hEEEE0266);
        read_chk(2'd2, 32'h00000266, "R3");
        read_chk(2'd3, 32'h0, "R3");

        // R2 doorbell
        bus_write(2'd0, 4'hF, 32'h1);
        check(mcu_irq == 1, "R2", mcu_irq, 1);
        read_chk(2'd0, 32'h1, "R2");
        // R10 control writes while busy
        bus_write(2'd0, 4'hF, 32'h0);
        check(mcu_irq == 1, "R10", mcu_irq, 1);
        bus_write(2'd0, 4'hF, 32'h1);
        read_chk(2'd0, 32'h1, "R10");
        // R4 overrun
        bus_write(2'd2, 4'hF, 32'h00000067);
        bus_write(2'd1, 4'hF, 32'h0);
        read_chk(2'd2, 32'h00000266, "R4");
        read_chk(2'd1, 32'h1122AA44, "R4");
        read_chk(2'd0, 32'h3, "R4");
        expq.push_back('{kind:2'd2, operand:8'h02, data:32'h1122AA44, dis:1'b0});
        pulse_done();
        check(mcu_irq == 0, "R5", mcu_irq, 0);
        @(negedge clk);
        check(cmd_valid == 0, "R5", cmd_valid, 0);

        // R6 done while idle
        pulse_done();
        check(cmd_valid == 0, "R6", cmd_valid, 0);
        check(mcu_irq == 0, "R6", mcu_irq, 0);

        // R7 level: operand from byte 2, byte 1 decoy
        send(32'h002A9965, 32'h00001234, '{kind:2'd1, operand:8'h2A, data:32'h1234, dis:1'b0});
        // R8 pipe disable code
        send(32'h003CFF66, 32'h0000FFFF, '{kind:2'd2, operand:8'hFF, data:32'hFFFF, dis:1'b1});
        // R9 backlight index 0 forces data 0
        send(32'h00770067, 32'h00000050, '{kind:2'd3, operand:8'h00, data:32'h0, dis:1'b0});
        // R9 backlight index 1 keeps data
        send(32'h00000167, 32'h00000050, '{kind:2'd3, operand:8'h01, data:32'h50, dis:1'b0});
        // R7 unknown opcode
        send(32'h12345612, 32'hCAFE0000, '{kind:2'd0, operand:8'h00, data:32'hCAFE0000, dis:1'b0});

        read_chk(2'd0, 32'h2, "R4");
        check(expq.size() == 0, "R5", expq.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule